// File: doc/BRIEF.md
# USB High-Speed Compliance Test Transmit Sequencer

This block owns the transmit byte path of a high-speed USB device controller while the controller sits in one of the compliance test modes. A small register, written through a two-address write port, selects the mode and holds a "payload ready" flag. In packet mode the block fetches a fixed-length test payload from a synchronous byte buffer that stands in for the control-endpoint FIFO. It wraps the payload in a DATA0 PID and a CRC-16 and then sends it again and again, with a fixed idle gap between copies.

In the two line-state modes the block drives a constant J or K code and sends no bytes. In the NAK-only mode it answers each valid IN token, which arrives as a decoded one-cycle pulse, with a single NAK handshake byte. Two further register bits fix the bus speed that the next host bus reset selects. The output is a byte stream with valid and last flags, plus a 2-bit line-state code for the downstream serializer. There is no backpressure: one byte leaves per clock while a frame is in flight.

Top module: `hs_test_seq`

## Requirements
- R1: While reset is asserted and after it is released with no register writes, tx_valid and tx_last are 0, line_st is 0 (idle) and hs_sel is 0.
- R2: A write to cfg_addr 0 loads the mode register: bit 0 packet mode, bit 1 K mode, bit 2 J mode, bit 3 NAK mode, bit 4 force full speed, bit 5 force high speed. A write to cfg_addr 1 loads the payload-ready flag from bit 0. The packet bit is stored only if the ready flag is already 1 when the mode write happens. Otherwise the write sends no bytes.
- R3: A packet is one DATA0 byte 0xC3, then the PAY_LEN (default 53) payload bytes read from buffer addresses 0, 1, ... PAY_LEN-1 in order, then two CRC bytes. tx_last is 1 only on the final CRC byte. line_st is 3 on every byte sent.
- R4: The CRC is the USB data CRC-16 (polynomial x^16+x^15+x^2+1, processed LSB first, seed 0xFFFF, result inverted), computed over the payload only and sent low byte first.
- R5: While packet mode stays set, packets repeat endlessly, with exactly GAP_CYC (default 4) cycles of tx_valid=0 between the last byte of one packet and the PID of the next.
- R6: Clearing the packet bit lets the packet in flight finish. After that no further byte is sent.
- R7: In K mode line_st holds 2 and in J mode it holds 1, continuously, with tx_valid 0.
- R8: In NAK mode, a tok_in_vld pulse produces, in the following cycle, one byte 0x5A with tx_last=1. In any other mode, or with no mode set, tok_in_vld produces no byte.
- R9: When several mode bits are set, the first in the order packet, K, J, NAK is the one that acts. The others have no effect.
- R10: On a cycle with bus_rst=1, hs_sel is loaded in the next cycle: 0 if force full speed is set, else 1 if force high speed is set, else the value of chirp_ok. hs_sel does not change on any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 mode, 1 payload ready |
| cfg_wdata | input | 6 | Register write data |
| bus_rst | input | 1 | Host bus reset detected (one-cycle pulse) |
| chirp_ok | input | 1 | High-speed handshake result used when no speed is forced |
| tok_in_vld | input | 1 | Valid IN token received (one-cycle pulse) |
| buf_addr | output | 6 | Payload buffer read address |
| buf_data | input | 8 | Payload buffer read data, one cycle after buf_addr |
| tx_valid | output | 1 | Byte present on tx_data |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of a packet or handshake |
| line_st | output | 2 | Line code: 0 idle, 1 J, 2 K, 3 data |
| hs_sel | output | 1 | High-speed operation selected |

## Verification
The hardest situation to reach is a change of mode inside a packet stream. The packet bit must be cleared in the middle of a packet so that the run stops cleanly, and it must be cleared again inside the inter-packet gap when another mode bit is set alongside it. The bench gets there by waiting on its own count of completed packets, as seen on tx_last, and then issuing the write a known number of cycles later. The scoreboard is preloaded with exactly the packets that should appear, so any trailing or restarted packet shows up as an unexpected byte. The idle gap is measured between every pair of packets in the run.

// File: rtl/hs_test_pkg.sv
package hs_test_pkg;

  localparam int CFG_W = 6;
  localparam int NMODE = 4;

  localparam logic [7:0] PID_DATA0 = 8'hC3;
  localparam logic [7:0] PID_NAK   = 8'h5A;

  localparam logic ADDR_MODE = 1'b0;
  localparam logic ADDR_RDY  = 1'b1;

  typedef enum logic [1:0] {
    LS_IDLE = 2'd0,
    LS_J    = 2'd1,
    LS_K    = 2'd2,
    LS_DATA = 2'd3
  } line_e;

  typedef enum logic [2:0] {
    TM_NONE, TM_PKT, TM_K, TM_J, TM_NAK
  } tmode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PID, S_PAY, S_CRCL, S_CRCH, S_GAP, S_NAK
  } tx_st_e;

  // one byte of the reflected USB data CRC-16
  function automatic logic [15:0] crc16_byte(logic [15:0] c, logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/hs_crc16.sv
module hs_crc16
  import hs_test_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc_o
);

  logic [15:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = 16'hFFFF;
    else if (en) crc_d = crc16_byte(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= 16'hFFFF;
    else        crc_q <= crc_d;
  end

  assign crc_o = crc_q;

  AST_CRC_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> crc_o == 16'hFFFF); // R4

endmodule

// File: rtl/hs_mode_arb.sv
module hs_mode_arb
  import hs_test_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             bus_rst,
  input  logic             chirp_ok,
  output tmode_e           mode,
  output logic             hs_sel
);

  logic [NMODE-1:0] en_q, en_d, sel;
  logic rdy_q, rdy_d, ffs_q, ffs_d, fhs_q, fhs_d, hs_q, hs_d;

  always_comb begin
    en_d  = en_q;
    rdy_d = rdy_q;
    ffs_d = ffs_q;
    fhs_d = fhs_q;
    hs_d  = hs_q;
    if (wr_en && wr_addr == ADDR_MODE) begin
      en_d    = wr_data[NMODE-1:0];
      en_d[0] = wr_data[0] & rdy_q;
      ffs_d   = wr_data[4];
      fhs_d   = wr_data[5];
    end
    if (wr_en && wr_addr == ADDR_RDY) rdy_d = wr_data[0];
    if (bus_rst) hs_d = ffs_q ? 1'b0 : (fhs_q ? 1'b1 : chirp_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      rdy_q <= 1'b0;
      ffs_q <= 1'b0;
      fhs_q <= 1'b0;
      hs_q  <= 1'b0;
    end else begin
      en_q  <= en_d;
      rdy_q <= rdy_d;
      ffs_q <= ffs_d;
      fhs_q <= fhs_d;
      hs_q  <= hs_d;
    end
  end

  // fixed priority: lower bit wins
  for (genvar i = 0; i < NMODE; i++) begin : g_pri
    if (i == 0) begin : g_head
      assign sel[i] = en_q[i];
    end else begin : g_tail
      assign sel[i] = en_q[i] & ~(|en_q[i-1:0]);
    end
  end

  always_comb begin
    mode = TM_NONE;
    if (sel[0])      mode = TM_PKT;
    else if (sel[1]) mode = TM_K;
    else if (sel[2]) mode = TM_J;
    else if (sel[3]) mode = TM_NAK;
  end

  assign hs_sel = hs_q;

  AST_PKT_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q[0]) |-> $past(rdy_q)); // R2

  AST_SPEED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rst) |-> $stable(hs_sel)); // R10

endmodule

// File: rtl/hs_test_seq.sv
module hs_test_seq
  import hs_test_pkg::*;
#(
  parameter int PAY_LEN = 53,
  parameter int GAP_CYC = 4,
  localparam int AW = $clog2(PAY_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             bus_rst,
  input  logic             chirp_ok,
  input  logic             tok_in_vld,
  output logic [AW-1:0]    buf_addr,
  input  logic [7:0]       buf_data,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic [1:0]       line_st,
  output logic             hs_sel
);

  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(PAY_LEN - 1);
  localparam logic [GW-1:0] GAP_LOAD = GW'(GAP_CYC - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  tmode_e      mode;
  logic [15:0] crc;
  tx_st_e      st_q, st_d;
  logic [AW-1:0] idx_q, idx_d;
  logic [GW-1:0] gap_q, gap_d;
  line_e       line_c;

  hs_mode_arb u_arb (
    .clk(clk), .rst_n(rst_s), .wr_en(cfg_wr), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .bus_rst(bus_rst), .chirp_ok(chirp_ok),
    .mode(mode), .hs_sel(hs_sel)
  );

  hs_crc16 u_crc (
    .clk(clk), .rst_n(rst_s), .clr(st_q == S_PID), .en(st_q == S_PAY),
    .din(buf_data), .crc_o(crc)
  );

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    gap_d = gap_q;
    unique case (st_q)
      S_IDLE: begin
        if (mode == TM_PKT)                    st_d = S_PID;
        else if (mode == TM_NAK && tok_in_vld) st_d = S_NAK;
      end
      S_PID: begin
        st_d  = S_PAY;
        idx_d = '0;
      end
      S_PAY: begin
        if (idx_q == LAST_IDX) st_d = S_CRCL;
        else                   idx_d = idx_q + 1'b1;
      end
      S_CRCL: st_d = S_CRCH;
      S_CRCH: begin
        st_d  = S_GAP;
        gap_d = GAP_LOAD;
      end
      S_GAP: begin
        if (gap_q != '0)         gap_d = gap_q - 1'b1;
        else if (mode == TM_PKT) st_d = S_PID;
        else                     st_d = S_IDLE;
      end
      S_NAK:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
      gap_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      gap_q <= gap_d;
    end
  end

  // read address runs one byte ahead of the byte on tx_data
  assign buf_addr = (st_q == S_PAY && idx_q != LAST_IDX) ? idx_q + 1'b1 : '0;

  always_comb begin
    tx_valid = 1'b1;
    tx_last  = 1'b0;
    tx_data  = 8'h00;
    unique case (st_q)
      S_PID:  tx_data = PID_DATA0;
      S_PAY:  tx_data = buf_data;
      S_CRCL: tx_data = ~crc[7:0];
      S_CRCH: begin tx_data = ~crc[15:8]; tx_last = 1'b1; end
      S_NAK:  begin tx_data = PID_NAK;    tx_last = 1'b1; end
      default: tx_valid = 1'b0;
    endcase
  end

  always_comb begin
    if (tx_valid)                              line_c = LS_DATA;
    else if (st_q == S_IDLE && mode == TM_K)   line_c = LS_K;
    else if (st_q == S_IDLE && mode == TM_J)   line_c = LS_J;
    else                                       line_c = LS_IDLE;
  end
  assign line_st = line_c;

  AST_PAY_LEN: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == S_CRCL) |-> ($past(st_q) == S_PAY && $past(idx_q) == LAST_IDX)); // R3

  AST_GAP_LEN: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == S_PID && $past(st_q) == S_GAP) |-> $past(gap_q) == '0); // R5

  AST_NAK_CAUSE: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == S_NAK) |-> ($past(tok_in_vld) && $past(mode) == TM_NAK)); // R8

endmodule

// File: tb/hs_test_seq_tb_top.sv
module hs_test_seq_tb_top;

  localparam int PAY = 53;
  localparam int GAP = 4;
  localparam int AW  = $clog2(PAY);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_addr = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic bus_rst = 1'b0, chirp_ok = 1'b0, tok_in_vld = 1'b0;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_data;
  logic tx_valid, tx_last, hs_sel;
  logic [7:0] tx_data;
  logic [1:0] line_st;

  always #5 clk = ~clk;

  hs_test_seq #(.PAY_LEN(PAY), .GAP_CYC(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bus_rst(bus_rst), .chirp_ok(chirp_ok),
    .tok_in_vld(tok_in_vld), .buf_addr(buf_addr), .buf_data(buf_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .line_st(line_st), .hs_sel(hs_sel)
  );

  // payload buffer model, synchronous read
  logic [7:0] mem [0:63];
  always @(posedge clk) buf_data <= mem[buf_addr];

  int checks = 0, errors = 0;
  int nbytes = 0, pkts = 0, idle_run = 0;
  bit seen_last = 1'b0, gap_chk = 1'b0;
  logic [8:0] exp_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // reference CRC: serial bit form of the USB data CRC-16
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic fb;
    for (int b = 0; b < 8; b++) begin
      fb = c[0] ^ d[b];
      c  = {1'b0, c[15:1]};
      if (fb) c = c ^ 16'hA001;
    end
    return c;
  endfunction

  task automatic push_pkt();
    logic [15:0] c = 16'hFFFF;
    exp_q.push_back({1'b0, 8'hC3});
    for (int i = 0; i < PAY; i++) begin
      exp_q.push_back({1'b0, mem[i]});
      c = ref_crc(c, mem[i]);
    end
    c = ~c;
    exp_q.push_back({1'b0, c[7:0]});
    exp_q.push_back({1'b1, c[15:8]});
  endtask

  task automatic wr(input logic a, input logic [5:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_tok();
    @(negedge clk); tok_in_vld = 1'b1;
    @(negedge clk); tok_in_vld = 1'b0;
  endtask

  task automatic pulse_brst();
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
  endtask

  // monitor: pops the scoreboard on every byte
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid) begin
        nbytes++;
        chk(line_st == 2'd3, "R3 line code on byte", line_st, 3);
        if (gap_chk && seen_last)
          chk(idle_run == GAP, "R5 inter-packet gap", idle_run, GAP);
        seen_last = 1'b0;
        idle_run  = 0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 R8 R9 unexpected byte", {tx_last, tx_data}, 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({tx_last, tx_data} == e, "R3 R4 byte/last", {tx_last, tx_data}, e);
        end
        if (tx_last) begin
          pkts++;
          seen_last = 1'b1;
        end
      end else begin
        idle_run++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nb0, p0;
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 29 + 7);
    chk(ref_crc(ref_crc(16'hFFFF, 8'h31), 8'h32) != 16'h0, "R4 reference sanity", 1, 1);
    begin
      logic [15:0] c = 16'hFFFF;
      for (int i = 0; i < 9; i++) c = ref_crc(c, 8'(8'h31 + i));
      chk(~c == 16'hB4C8, "R4 reference check value", ~c, 16'hB4C8);
    end
    repeat (3) @(negedge clk);
    chk(tx_valid == 0 && tx_last == 0 && line_st == 0 && hs_sel == 0, "R1 in reset",
        {tx_valid, tx_last, line_st, hs_sel}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_valid == 0 && line_st == 0 && hs_sel == 0, "R1 after reset",
        {tx_valid, line_st, hs_sel}, 0);

    // R2: packet bit without ready flag does nothing
    nb0 = nbytes;
    wr(1'b0, 6'h01);
    repeat (40) @(negedge clk);
    chk(nbytes == nb0 && line_st == 0, "R2 packet bit ignored without ready", nbytes - nb0, 0);

    // R3 R4 R5 R6: repeated packets, stop mid-packet
    wr(1'b1, 6'h01);
    push_pkt(); push_pkt(); push_pkt();
    gap_chk = 1'b1;
    wr(1'b0, 6'h01);
    wait (pkts == 2);
    repeat (10) @(negedge clk);
    wr(1'b0, 6'h00);
    repeat (150) @(negedge clk);
    gap_chk = 1'b0;
    chk(pkts == 3, "R6 in-flight packet completes", pkts, 3);
    chk(exp_q.size() == 0, "R3 all expected bytes seen", exp_q.size(), 0);
    chk(tx_valid == 0 && line_st == 0, "R6 line idle after stop", line_st, 0);

    // R7: line-state modes
    wr(1'b0, 6'h02);
    nb0 = nbytes;
    repeat (10) @(negedge clk);
    chk(line_st == 2'd2 && tx_valid == 0, "R7 K state", line_st, 2);
    wr(1'b0, 6'h04);
    repeat (10) @(negedge clk);
    chk(line_st == 2'd1 && tx_valid == 0, "R7 J state", line_st, 1);
    chk(nbytes == nb0, "R7 no bytes in line modes", nbytes - nb0, 0);

    // R9: priority among line and NAK modes
    wr(1'b0, 6'h0E);
    repeat (2) @(negedge clk);
    chk(line_st == 2'd2, "R9 K over J and NAK", line_st, 2);
    pulse_tok();
    repeat (4) @(negedge clk);
    chk(nbytes == nb0, "R9 token ignored under K", nbytes - nb0, 0);
    wr(1'b0, 6'h0C);
    repeat (2) @(negedge clk);
    chk(line_st == 2'd1, "R9 J over NAK", line_st, 1);
    pulse_tok();
    repeat (4) @(negedge clk);
    chk(nbytes == nb0, "R9 token ignored under J", nbytes - nb0, 0);

    // R8: NAK mode
    wr(1'b0, 6'h08);
    exp_q.push_back({1'b1, 8'h5A});
    @(negedge clk); tok_in_vld = 1'b1;
    @(negedge clk); tok_in_vld = 1'b0;
    chk(tx_valid == 1 && tx_data == 8'h5A && tx_last == 1, "R8 NAK next cycle",
        {tx_valid, tx_last, tx_data}, 10'h35A);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && nbytes == nb0 + 1, "R8 exactly one NAK", nbytes - nb0, 1);
    wr(1'b0, 6'h00);
    pulse_tok();
    repeat (4) @(negedge clk);
    chk(nbytes == nb0 + 1, "R8 token ignored with no mode", nbytes - nb0, 1);

    // R9: packet over K, second payload pattern, clear inside the gap
    for (int i = 0; i < 64; i++) mem[i] = 8'hF0 ^ 8'(i);
    push_pkt();
    p0 = pkts;
    wr(1'b0, 6'h03);
    wait (pkts == p0 + 1);
    wr(1'b0, 6'h00);
    repeat (80) @(negedge clk);
    chk(pkts == p0 + 1 && exp_q.size() == 0, "R9 packet wins over K, single packet",
        pkts - p0, 1);

    // R10: speed after bus reset
    wr(1'b0, 6'h10); chirp_ok = 1'b1; pulse_brst();
    chk(hs_sel == 0, "R10 force full speed", hs_sel, 0);
    wr(1'b0, 6'h20); chirp_ok = 1'b0; pulse_brst();
    chk(hs_sel == 1, "R10 force high speed", hs_sel, 1);
    wr(1'b0, 6'h00); chirp_ok = 1'b0;
    repeat (3) @(negedge clk);
    chk(hs_sel == 1, "R10 holds without bus reset", hs_sel, 1);
    pulse_brst();
    chk(hs_sel == 0, "R10 follows handshake low", hs_sel, 0);
    chirp_ok = 1'b1; pulse_brst();
    chk(hs_sel == 1, "R10 follows handshake high", hs_sel, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule